// File: doc/BRIEF.md
# Dual-Path Bypass Switch Allocator

This block decides, every cycle, which input of a virtual-channel router may drive each crossbar output. A router has `P` input ports, each with `V` virtual channels (VCs). Flits reach the switch in one of two ways, and the allocator keeps a separate request path for each.

A flit that has just arrived at an input may skip its buffer and cross in the cycle it arrives. It may do so only when its input has nothing buffered and its downstream credit is present. This is the fast path, and it is combinational from the arrival signals to the grant. Flits already held in buffers use the slow path. One cycle ahead of allocation, each input picks its next VC in round-robin order among the VCs that hold flits, have a credit and are cleared to move. It registers that choice, so the allocation cycle starts from settled requests.

Each output has one round-robin arbiter per path, and a slow-path winner always displaces a fast-path winner. Every arriving flit is also written to its buffer. When `xbarBypass` is high for an input, the buffer logic drops that write, so a flit is never sent twice. A flit that loses the bypass stays queued and competes on the slow path later. Buffers, the crossbar and VC assignment sit outside this block.

Top module: `sw_bypass_alloc`

## Requirements
- R1: An input whose new flit is valid, has its credit, finds no buffered flit at its input and wins its output is granted in the same cycle. `xbarBypass` is high, `xbarGrantVc` equals the arriving VC and `xbarGrantOut` equals the arriving destination.
- R2: No bypass is granted at an input while any of its VCs holds buffered flits, or while that input has a preselected slow-path request.
- R3: A new flit whose credit input is low never requests the fast path.
- R4: At each input, the slow path preselects the next VC round-robin among ready VCs, starting after the VC last granted. A VC granted in one cycle is not offered again in the next cycle, so a grant is never issued twice for the same flit.
- R5: Credit and clearance of a buffered VC are sampled in the cycle before its grant. A VC that becomes ready in cycle t is granted no earlier than cycle t+1.
- R6: When slow-path and fast-path winners target the same output, only the slow-path winner is granted.
- R7: Each output arbitrates among inputs round-robin, with one pointer per path. A pointer moves past the winner only when that path's grant is issued, so with `P` inputs competing on the slow path each one is served within `P` cycles.
- R8: At most one input is granted per output and at most one flit per input in a cycle. An input without a grant drives zero on `xbarGrantVc`, `xbarGrantOut` and `xbarBypass`.
- R9: Reset (active-low `rst_n`, asynchronous) clears every preselection and sets all round-robin pointers to zero. No slow-path grant appears before one clock edge after reset has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| newFlitValid | input | P | A new flit is arriving at each input this cycle |
| newFlitVc | input | P*VW | VC of the arriving flit, per input |
| newFlitDest | input | P*PW | Output port routed for the arriving flit |
| newFlitCredit | input | P | Downstream credit present for the arriving flit |
| bufVcActive | input | P*V | VC v of input p holds flits, bit p*V+v |
| bufVcCredit | input | P*V | Downstream credit present for that VC's head flit |
| bufVcCleared | input | P*V | That VC's head flit is allowed to move |
| bufVcDest | input | P*V*PW | Output port of that VC's head flit, field p*V+v |
| xbarGrant | output | P | Input p is granted this cycle |
| xbarBypass | output | P | The grant goes to the arriving flit; its buffer write is to be dropped |
| xbarGrantVc | output | P*VW | VC served at each granted input |
| xbarGrantOut | output | P*PW | Output port given to each granted input |

## Verification
The hardest situation to reach from the ports is a buffered flit that competes with a steady stream of bypass attempts at the same output. The preselection stage adds a cycle, so the two requests overlap only if the buffered VC is made ready one cycle before the arrival that it has to beat. The stimulus sets a buffered VC ready while a different idle input is sending arrivals to the same output every cycle. It then checks that the bypass wins the first cycle and the buffered flit takes the second. Separate sequences keep every input's VC0 busy toward one output, which walks the slow pointer across all inputs. They also hold a VC active across its own grant to show that it is not offered again.

// File: rtl/sw_bypass_alloc_pkg.sv
package sw_bypass_alloc_pkg;

  // request strobes handed from the request control to the grant path
  typedef struct packed {
    logic slowReq;   // registered buffered-flit request
    logic fastReq;   // same-cycle bypass request
  } reqStrobe_t;

endpackage

// File: rtl/swa_rr_arb.sv
module swa_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] prio;
  logic [IW-1:0] winIdx;
  logic          hit;

  // first requester at or after the priority position wins
  always_comb begin
    int idx;
    gnt    = '0;
    winIdx = '0;
    hit    = 1'b0;
    for (int k = 0; k < N; k++) begin
      idx = (int'(prio) + k) % N;
      if (!hit && req[idx]) begin
        gnt[idx] = 1'b1;
        winIdx   = IW'(idx);
        hit      = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio <= '0;
    end else if (adv && hit) begin
      prio <= (int'(winIdx) == N - 1) ? '0 : winIdx + 1'b1;
    end
  end

endmodule

// File: rtl/swa_req_ctrl.sv
module swa_req_ctrl
  import sw_bypass_alloc_pkg::*;
#(
  parameter int P  = 4,
  parameter int V  = 2,
  parameter int VW = 1,
  parameter int PW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [P-1:0]          newFlitValid,
  input  logic [P-1:0]          newFlitCredit,
  input  logic [P*V-1:0]        bufVcActive,
  input  logic [P*V-1:0]        bufVcCredit,
  input  logic [P*V-1:0]        bufVcCleared,
  input  logic [P*V*PW-1:0]     bufVcDest,
  input  logic [P-1:0]          slowGranted,
  output reqStrobe_t [P-1:0]    strobe,
  output logic [P*VW-1:0]       selVc,
  output logic [P*PW-1:0]       selDest
);

  for (genvar p = 0; p < P; p++) begin : g_in
    logic [V-1:0]  act;
    logic [V-1:0]  ready;
    logic [VW-1:0] ptr;
    logic [VW-1:0] pick;
    logic [PW-1:0] pickDest;
    logic          anyReady;
    logic          selValidQ;
    logic [VW-1:0] selVcQ;
    logic [PW-1:0] selDestQ;

    assign act = bufVcActive[p*V +: V];

    // one-cycle-ahead preselection; the VC being granted now is held out
    always_comb begin
      int idx;
      ready = act & bufVcCredit[p*V +: V] & bufVcCleared[p*V +: V];
      if (slowGranted[p]) ready[selVcQ] = 1'b0;
      pick     = '0;
      anyReady = 1'b0;
      for (int k = 0; k < V; k++) begin
        idx = (int'(ptr) + k) % V;
        if (!anyReady && ready[idx]) begin
          pick     = VW'(idx);
          anyReady = 1'b1;
        end
      end
      pickDest = bufVcDest[(p*V + int'(pick))*PW +: PW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        selValidQ <= 1'b0;
        selVcQ    <= '0;
        selDestQ  <= '0;
        ptr       <= '0;
      end else begin
        selValidQ <= anyReady;
        selVcQ    <= pick;
        selDestQ  <= pickDest;
        if (slowGranted[p]) begin
          ptr <= (int'(selVcQ) == V - 1) ? '0 : selVcQ + 1'b1;
        end
      end
    end

    assign strobe[p].slowReq = selValidQ;
    assign strobe[p].fastReq = newFlitValid[p] & newFlitCredit[p] & ~(|act) & ~selValidQ;
    assign selVc[p*VW +: VW]   = selVcQ;
    assign selDest[p*PW +: PW] = selDestQ;

    // R4: the VC just granted is never granted again in the following cycle
    p_no_repeat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      slowGranted[p] |=> !(slowGranted[p] && selVcQ == $past(selVcQ)));

    // R2: a slow request at an input excludes a bypass request there
    p_fast_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      strobe[p].slowReq |-> !strobe[p].fastReq);
  end

endmodule

// File: rtl/swa_grant_path.sv
module swa_grant_path
  import sw_bypass_alloc_pkg::*;
#(
  parameter int P  = 4,
  parameter int VW = 1,
  parameter int PW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  reqStrobe_t [P-1:0] strobe,
  input  logic [P*VW-1:0]    selVc,
  input  logic [P*PW-1:0]    selDest,
  input  logic [P*VW-1:0]    newFlitVc,
  input  logic [P*PW-1:0]    newFlitDest,
  output logic [P-1:0]       slowGranted,
  output logic [P-1:0]       xbarGrant,
  output logic [P-1:0]       xbarBypass,
  output logic [P*VW-1:0]    xbarGrantVc,
  output logic [P*PW-1:0]    xbarGrantOut
);

  logic [P-1:0] slowReqM [P];
  logic [P-1:0] fastReqM [P];
  logic [P-1:0] slowWin  [P];
  logic [P-1:0] fastRaw  [P];
  logic [P-1:0] fastWin  [P];
  logic [P-1:0] slowBusy;
  logic [P-1:0] fastHit;

  // request matrices, indexed [output][input]
  always_comb begin
    for (int o = 0; o < P; o++) begin
      for (int p = 0; p < P; p++) begin
        slowReqM[o][p] = strobe[p].slowReq && (selDest[p*PW +: PW] == PW'(o));
        fastReqM[o][p] = strobe[p].fastReq && (newFlitDest[p*PW +: PW] == PW'(o));
      end
      slowBusy[o] = |slowReqM[o];
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_out
    swa_rr_arb #(.N(P)) u_slowArb (
      .clk(clk), .rst_n(rst_n), .req(slowReqM[o]), .adv(1'b1), .gnt(slowWin[o]));
    swa_rr_arb #(.N(P)) u_fastArb (
      .clk(clk), .rst_n(rst_n), .req(fastReqM[o]), .adv(~slowBusy[o]), .gnt(fastRaw[o]));

    assign fastWin[o] = slowBusy[o] ? '0 : fastRaw[o];

    // R8: one input per output
    p_one_per_output_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slowWin[o] | fastWin[o]));
    // R6: a slow request at an output leaves no bypass winner there
    p_slow_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      slowBusy[o] |-> fastWin[o] == '0);
  end

  always_comb begin
    slowGranted = '0;
    fastHit     = '0;
    for (int o = 0; o < P; o++) begin
      slowGranted = slowGranted | slowWin[o];
      fastHit     = fastHit | fastWin[o];
    end
  end

  for (genvar p = 0; p < P; p++) begin : g_in
    logic [P-1:0] column;
    always_comb begin
      for (int o = 0; o < P; o++) column[o] = slowWin[o][p] | fastWin[o][p];
    end

    assign xbarGrant[p]  = slowGranted[p] | fastHit[p];
    assign xbarBypass[p] = fastHit[p];
    assign xbarGrantVc[p*VW +: VW] = slowGranted[p] ? selVc[p*VW +: VW] :
                                     fastHit[p]     ? newFlitVc[p*VW +: VW] : '0;
    assign xbarGrantOut[p*PW +: PW] = slowGranted[p] ? selDest[p*PW +: PW] :
                                      fastHit[p]     ? newFlitDest[p*PW +: PW] : '0;

    // R8: one flit per input
    p_one_per_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(column));
  end

endmodule

// File: rtl/sw_bypass_alloc.sv
module sw_bypass_alloc
  import sw_bypass_alloc_pkg::*;
#(
  parameter int P = 4,
  parameter int V = 2,
  localparam int VW = (V > 1) ? $clog2(V) : 1,
  localparam int PW = (P > 1) ? $clog2(P) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [P-1:0]      newFlitValid,
  input  logic [P*VW-1:0]   newFlitVc,
  input  logic [P*PW-1:0]   newFlitDest,
  input  logic [P-1:0]      newFlitCredit,
  input  logic [P*V-1:0]    bufVcActive,
  input  logic [P*V-1:0]    bufVcCredit,
  input  logic [P*V-1:0]    bufVcCleared,
  input  logic [P*V*PW-1:0] bufVcDest,
  output logic [P-1:0]      xbarGrant,
  output logic [P-1:0]      xbarBypass,
  output logic [P*VW-1:0]   xbarGrantVc,
  output logic [P*PW-1:0]   xbarGrantOut
);

  reqStrobe_t [P-1:0] strobe;
  logic [P*VW-1:0]    selVc;
  logic [P*PW-1:0]    selDest;
  logic [P-1:0]       slowGranted;

  swa_req_ctrl #(.P(P), .V(V), .VW(VW), .PW(PW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .newFlitValid(newFlitValid), .newFlitCredit(newFlitCredit),
    .bufVcActive(bufVcActive), .bufVcCredit(bufVcCredit),
    .bufVcCleared(bufVcCleared), .bufVcDest(bufVcDest),
    .slowGranted(slowGranted), .strobe(strobe),
    .selVc(selVc), .selDest(selDest));

  swa_grant_path #(.P(P), .VW(VW), .PW(PW)) u_grant (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .selVc(selVc), .selDest(selDest),
    .newFlitVc(newFlitVc), .newFlitDest(newFlitDest),
    .slowGranted(slowGranted), .xbarGrant(xbarGrant), .xbarBypass(xbarBypass),
    .xbarGrantVc(xbarGrantVc), .xbarGrantOut(xbarGrantOut));

  for (genvar p = 0; p < P; p++) begin : g_chk
    // R2: bypass only for an arriving flit at an input with nothing buffered
    p_bypass_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xbarBypass[p] |-> (newFlitValid[p] && bufVcActive[p*V +: V] == '0));
  end

endmodule

// File: tb/sw_bypass_alloc_tb_top.sv
module sw_bypass_alloc_tb_top;

  localparam int P = 4;
  localparam int V = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  newFlitValid = '0;
  logic [3:0]  newFlitVc = '0;
  logic [7:0]  newFlitDest = '0;
  logic [3:0]  newFlitCredit = '0;
  logic [7:0]  bufVcActive = '0;
  logic [7:0]  bufVcCredit = '0;
  logic [7:0]  bufVcCleared = '0;
  logic [15:0] bufVcDest = '0;
  logic [3:0]  xbarGrant;
  logic [3:0]  xbarBypass;
  logic [3:0]  xbarGrantVc;
  logic [7:0]  xbarGrantOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  sw_bypass_alloc #(.P(P), .V(V)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .newFlitValid(newFlitValid), .newFlitVc(newFlitVc),
    .newFlitDest(newFlitDest), .newFlitCredit(newFlitCredit),
    .bufVcActive(bufVcActive), .bufVcCredit(bufVcCredit),
    .bufVcCleared(bufVcCleared), .bufVcDest(bufVcDest),
    .xbarGrant(xbarGrant), .xbarBypass(xbarBypass),
    .xbarGrantVc(xbarGrantVc), .xbarGrantOut(xbarGrantOut));

  typedef struct packed {
    logic [3:0] av;
    logic [3:0] avc;
    logic [7:0] ad;
    logic [3:0] ac;
    logic [3:0] eG;
    logic [3:0] eB;
    logic [3:0] eVc;
    logic [7:0] eO;
  } vec_t;

  // fast-path vectors, nothing buffered; applied in order from reset
  localparam vec_t VECS [6] = '{
    '{4'b0000, 4'b0000, 8'b0000_0000, 4'b0000, 4'b0000, 4'b0000, 4'b0000, 8'b0000_0000},
    '{4'b0001, 4'b0001, 8'b0000_0001, 4'b0001, 4'b0001, 4'b0001, 4'b0001, 8'b0000_0001},
    '{4'b0101, 4'b0000, 8'b0001_0001, 4'b0101, 4'b0100, 4'b0100, 4'b0000, 8'b0001_0000},
    '{4'b0101, 4'b0000, 8'b0001_0001, 4'b0101, 4'b0001, 4'b0001, 4'b0000, 8'b0000_0001},
    '{4'b1010, 4'b1000, 8'b0000_1000, 4'b1000, 4'b1000, 4'b1000, 4'b1000, 8'b0000_0000},
    '{4'b1111, 4'b0101, 8'b1110_0100, 4'b1111, 4'b1111, 4'b1111, 4'b0101, 8'b1110_0100}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic grantIs(input string req, input logic [3:0] g, input logic [3:0] b,
                         input logic [3:0] vc, input logic [7:0] o);
    check(req, "grant", 32'(xbarGrant), 32'(g));
    check(req, "bypass", 32'(xbarBypass), 32'(b));
    check(req, "vc", 32'(xbarGrantVc), 32'(vc));
    check(req, "out", 32'(xbarGrantOut), 32'(o));
  endtask

  task automatic clearIn();
    newFlitValid = '0; newFlitVc = '0; newFlitDest = '0; newFlitCredit = '0;
    bufVcActive = '0; bufVcCredit = '0; bufVcCleared = '0; bufVcDest = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      clearIn();
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    clearIn();
    repeat (3) @(negedge clk);
    #5;
    check("R9", "grant in reset", 32'(xbarGrant), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    grantIs("R9", 4'b0, 4'b0, 4'b0, 8'h0);

    // table walk: R1 fast grants, R3 credit gate, R7 fast pointer rotation
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      newFlitValid = VECS[i].av; newFlitVc = VECS[i].avc;
      newFlitDest = VECS[i].ad;  newFlitCredit = VECS[i].ac;
      #5;
      grantIs($sformatf("R1/R3/R7 vec%0d", i), VECS[i].eG, VECS[i].eB, VECS[i].eVc, VECS[i].eO);
    end

    // R2: arrival blocked while its input holds a buffered flit
    @(negedge clk);
    clearIn();
    newFlitValid = 4'b0001; newFlitDest = 8'b0000_0010; newFlitCredit = 4'b0001;
    bufVcActive = 8'b0000_0010;
    #5;
    grantIs("R2", 4'b0, 4'b0, 4'b0, 8'h0);
    @(negedge clk);
    clearIn();
    #5;
    check("R2", "no late grant", 32'(xbarGrant), 32'h0);

    // R4 basic slow grant, no repeat while VC stays active
    @(negedge clk);
    bufVcActive = 8'b0000_0100; bufVcCredit = 8'b0000_0100; bufVcCleared = 8'b0000_0100;
    bufVcDest = 16'h0030;
    #5;
    check("R5", "latency one cycle", 32'(xbarGrant), 32'h0);
    @(negedge clk); #5;
    grantIs("R4", 4'b0010, 4'b0, 4'b0, 8'b0000_1100);
    @(negedge clk); #5;
    check("R4", "no repeat next cycle", 32'(xbarGrant), 32'h0);
    @(negedge clk); #5;
    grantIs("R4", 4'b0010, 4'b0, 4'b0, 8'b0000_1100);
    @(negedge clk);
    clearIn();
    #5;
    check("R4", "drained", 32'(xbarGrant), 32'h0);

    // R5: credit and clearance sampled a cycle ahead
    @(negedge clk);
    bufVcActive = 8'b0010_0000; bufVcCleared = 8'b0010_0000; bufVcDest = 16'h0400;
    #5;
    check("R5", "no credit", 32'(xbarGrant), 32'h0);
    @(negedge clk);
    bufVcCredit = 8'b0010_0000; bufVcCleared = 8'b0;
    #5;
    check("R5", "credit late", 32'(xbarGrant), 32'h0);
    @(negedge clk);
    bufVcCleared = 8'b0010_0000;
    #5;
    check("R5", "clearance late", 32'(xbarGrant), 32'h0);
    @(negedge clk); #5;
    grantIs("R5", 4'b0100, 4'b0, 4'b0100, 8'b0001_0000);
    idle(2);

    // R4: VC round-robin at input 0
    @(negedge clk);
    bufVcActive = 8'b11; bufVcCredit = 8'b11; bufVcCleared = 8'b11; bufVcDest = 16'h0004;
    #5;
    check("R4", "preselect wait", 32'(xbarGrant), 32'h0);
    @(negedge clk); #5;
    grantIs("R4", 4'b0001, 4'b0, 4'b0000, 8'b0000_0000);
    @(negedge clk); #5;
    grantIs("R4", 4'b0001, 4'b0, 4'b0001, 8'b0000_0001);
    @(negedge clk); #5;
    grantIs("R4", 4'b0001, 4'b0, 4'b0000, 8'b0000_0000);
    idle(3);

    // R6: buffered flit beats a bypass stream at output 2
    @(negedge clk);
    bufVcActive = 8'b01; bufVcCredit = 8'b01; bufVcCleared = 8'b01; bufVcDest = 16'h0002;
    newFlitValid = 4'b1000; newFlitDest = 8'b1000_0000; newFlitCredit = 4'b1000;
    #5;
    grantIs("R6", 4'b1000, 4'b1000, 4'b0, 8'b1000_0000);
    @(negedge clk); #5;
    grantIs("R6", 4'b0001, 4'b0000, 4'b0, 8'b0000_0010);
    @(negedge clk);
    clearIn();
    #5;
    check("R6", "no second grant", 32'(xbarGrant), 32'h0);

    // R7: four inputs on the slow path to output 0, pointer starts at input 1
    @(negedge clk);
    bufVcActive = 8'b0101_0101; bufVcCredit = 8'b0101_0101; bufVcCleared = 8'b0101_0101;
    #5;
    check("R7", "preselect wait", 32'(xbarGrant), 32'h0);
    @(negedge clk); #5;
    grantIs("R7", 4'b0010, 4'b0, 4'b0, 8'h0);
    @(negedge clk); #5;
    grantIs("R7", 4'b0100, 4'b0, 4'b0, 8'h0);
    @(negedge clk); #5;
    grantIs("R7", 4'b1000, 4'b0, 4'b0, 8'h0);
    @(negedge clk); #5;
    grantIs("R7", 4'b0001, 4'b0, 4'b0, 8'h0);
    idle(3);

    // R9: reset drops a pending preselection
    @(negedge clk);
    bufVcActive = 8'b0000_0100; bufVcCredit = 8'b0000_0100; bufVcCleared = 8'b0000_0100;
    bufVcDest = 16'h0030;
    @(negedge clk);
    rst_n = 1'b0;
    #5;
    check("R9", "grant during reset", 32'(xbarGrant), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #5;
    check("R9", "first cycle after reset", 32'(xbarGrant), 32'h0);
    @(negedge clk); #5;
    grantIs("R9", 4'b0010, 4'b0, 4'b0, 8'b0000_1100);
    idle(2);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule